// File: doc/BRIEF.md
# Programmable Priority Arbiter for Seven DMA Channels

This block decides which of seven DMA channels owns the memory bus. A single 32-bit control word sets, for each channel, a 3-bit rank and an enable bit. Whenever the bus is free, the arbiter looks at every channel that is both requesting and enabled. It grants the bus to the one with the numerically smallest rank. If several channels share that rank, the highest channel number wins.

A channel keeps its grant for as long as it holds its request high, so a burst is never cut short. When the holder drops its request, the grant clears at the next clock edge. A fresh arbitration takes place on the edge after that. Software reads and writes the control word through a simple write strobe and a continuous readback. Bits 28 to 31 of the control word are stored and read back but do not influence arbitration.

Top module: `dma_prio_arbiter`

## Requirements
- R1: On reset the control word reads 0x07654321 and no grant is active, even if requests are present during reset.
- R2: A write with `cfg_we` high stores all 32 bits of `cfg_wdata` at the next rising edge, and `cfg_rdata` returns them. For channel n (0..6), bits [4n+2:4n] hold its rank and bit 4n+3 holds its enable.
- R3: When the bus is free, the eligible channel with the lowest rank value is granted; rank 0 is the most urgent and rank 7 the least.
- R4: Among eligible channels with equal lowest rank, the channel with the highest index is granted.
- R5: A channel whose enable bit is 0 is never newly granted, whatever its request and rank.
- R6: `gnt` is one-hot or all zero, and it stays all zero while no channel is both requesting and enabled.
- R7: While the granted channel keeps its request high, its grant persists unchanged, even if a better-ranked channel requests.
- R8: When the granted channel's request is low at a rising edge, `gnt` becomes zero at that edge. The next grant appears no earlier than the following edge.
- R9: An arbitration uses the control word as it stood before the arbitrating edge. A write landing on that edge, or while a grant is held, affects only later arbitrations.
- R10: Bits 28 to 31 of the control word have no effect on which channel is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| req | input | 7 | Per-channel bus request |
| gnt | output | 7 | One-hot bus grant |

## Verification
A control word write and an arbitration can land on the same clock edge. The bench provokes this by raising requests on a free bus in the same cycle that it writes a control word which reverses the ranking. It then checks that the granted channel follows the old word while the readback already shows the new one. The second collision is a re-ranking written while a grant is held. The bench checks that the holder keeps the bus and that the winner under the new ranking takes it only two edges after the holder releases. Around these cases, the bench sweeps every request pattern against a set of fixed and random control words. It compares each grant with a rank search computed inside the bench.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NCH = 7,
  parameter int PW = 3,
  parameter int RW = 32,
  parameter logic [RW-1:0] RST_VAL = 32'h07654321
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt
);
  localparam int FW = PW + 1;

  logic [RW-1:0]           cfg_q;
  logic [NCH-1:0][PW-1:0]  rank;
  logic [NCH-1:0]          en;
  logic [NCH-1:0]          elig;
  logic [NCH-1:0]          win;
  logic                    busy;
  logic                    held;

  for (genvar g = 0; g < NCH; g++) begin : g_field
    assign rank[g] = cfg_q[g*FW +: PW];
    assign en[g]   = cfg_q[g*FW + PW];
  end

  assign elig      = req & en;
  assign busy      = |gnt;
  assign held      = |(gnt & req);
  assign cfg_rdata = cfg_q;

  always_comb begin
    logic [PW-1:0] best;
    logic          found;
    win   = '0;
    best  = '1;
    found = 1'b0;
    for (int n = 0; n < NCH; n++) begin
      if (elig[n] && (!found || rank[n] <= best)) begin
        win    = '0;
        win[n] = 1'b1;
        best   = rank[n];
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gnt <= '0;
    else if (busy) begin
      if (!held)    gnt <= '0;
    end
    else            gnt <= win;
  end

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && elig == '0) |=> (gnt == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(gnt));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !held) |=> (gnt == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt[g]) |-> ($past(en[g]) && $past(req[g])));
  end
endmodule

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [6:0]  req = '0;
  logic [6:0]  gnt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_prio_arbiter i_dma_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req(req), .gnt(gnt)
  );

  function automatic logic [6:0] expect_gnt(logic [31:0] c, logic [6:0] r);
    int best = 8;
    int idx = -1;
    for (int n = 6; n >= 0; n--) begin
      if (r[n] && c[4*n+3] && int'(c[4*n +: 3]) < best) begin
        best = int'(c[4*n +: 3]);
        idx = n;
      end
    end
    return (idx < 0) ? 7'h00 : 7'(1 << idx);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic arb_one(logic [31:0] c, logic [6:0] r);
    req = r;
    @(negedge clk);
    chk("R3/R4/R5/R10 sweep grant", {25'd0, gnt}, {25'd0, expect_gnt(c, r)});
    req = '0;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cfgs [0:47];
    req = 7'h7F;
    repeat (3) @(negedge clk);
    chk("R1 reset word", cfg_rdata, 32'h07654321);
    chk("R1 reset grant", {25'd0, gnt}, 32'd0);
    req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant after reset", {25'd0, gnt}, 32'd0);

    wr(32'hA5A5A5A5);
    chk("R2 readback", cfg_rdata, 32'hA5A5A5A5);
    wr(32'h5A5A5A5A);
    chk("R2 readback", cfg_rdata, 32'h5A5A5A5A);

    cfgs[0] = 32'h07654321;
    cfgs[1] = 32'h08888888;
    cfgs[2] = 32'hFFFFFFFF;
    cfgs[3] = 32'h0F9ABCDE;
    cfgs[4] = 32'h07777777;
    cfgs[5] = 32'hF0000000;
    cfgs[6] = 32'h0CCCCCCC;
    cfgs[7] = 32'h89ABCDEF;
    for (int i = 8; i < 48; i++) cfgs[i] = $urandom;
    for (int i = 0; i < 48; i++) begin
      wr(cfgs[i]);
      chk("R2 sweep readback", cfg_rdata, cfgs[i]);
      for (int r = 0; r < 128; r++) arb_one(cfgs[i], 7'(r));
    end

    wr(32'h07777777);
    req = 7'h7F;
    repeat (3) begin
      @(negedge clk);
      chk("R5 all disabled", {25'd0, gnt}, 32'd0);
    end
    req = '0;

    wr(32'h0FFFFFF8);
    arb_one(32'h0FFFFFF8, 7'h7F);
    wr(32'hFFFFFFF8);
    arb_one(32'hFFFFFFF8, 7'h7F);
    wr(32'h0FFFFFFF);
    req = 7'h7F;
    @(negedge clk);
    chk("R4 equal ranks high index", {25'd0, gnt}, 32'h40);
    req = '0;
    @(negedge clk);

    wr(32'h0FFFFFF8);
    req = 7'h7F;
    @(negedge clk);
    chk("R3 ch0 granted", {25'd0, gnt}, 32'h01);
    cfg_we = 1'b1;
    cfg_wdata = 32'h08FFFFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 write while held", {25'd0, gnt}, 32'h01);
    repeat (2) begin
      @(negedge clk);
      chk("R7 hold against better rank", {25'd0, gnt}, 32'h01);
    end
    req[0] = 1'b0;
    @(negedge clk);
    chk("R8 release clears grant", {25'd0, gnt}, 32'd0);
    @(negedge clk);
    chk("R8 R9 next winner new word", {25'd0, gnt}, 32'h40);
    req = '0;
    repeat (2) @(negedge clk);
    chk("R8 idle after release", {25'd0, gnt}, 32'd0);

    req = 7'h7F;
    cfg_we = 1'b1;
    cfg_wdata = 32'h0FFFFFF8;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 same edge uses old word", {25'd0, gnt}, 32'h40);
    chk("R9 same edge readback", cfg_rdata, 32'h0FFFFFF8);
    req = '0;
    repeat (2) @(negedge clk);
    req = 7'h7F;
    @(negedge clk);
    chk("R9 later arbitration new word", {25'd0, gnt}, 32'h01);
    req = '0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule